// File: doc/BRIEF.md
# Speculative Store-to-Load Forwarding Unit

This block lets a load pick up a value from an earlier store before the load's own address has been computed. Each store and each load carries a small hint that travels with the instruction. A store hint holds a 2-bit saturating filter, an index-valid flag and a value-file index. A load hint holds a confidence bit and a value-file index. At issue, a store whose hint has a valid index and an open filter deposits its data, or a tag standing for it, into a value file. A load whose confidence bit is set reads the value file at its hint index and gets the result one cycle later.

After execution, a shared resolve port gives each store and each load to a set-associative store cache keyed by store address. A store is recorded there along with its value-file index. A store that has no index yet takes one from a round-robin allocator. A store that already has an index gets its filter trained: the filter moves up if some load used the store's entry since the store last resolved, and down if none did. A load looks up its real address to find the real producer. It then takes that producer's index and gets its confidence set or cleared. If the value it was given speculatively differs from the real data, a misprediction is flagged.

A three-state machine sequences the resolve port. From RS_IDLE, RS_STORE_RSP or RS_LOAD_RSP, a resolve request with the load flag low moves to RS_STORE_RSP, one with the load flag high moves to RS_LOAD_RSP, and a cycle with no request moves to RS_IDLE. The store response valid is high only in RS_STORE_RSP. The load response valid is high only in RS_LOAD_RSP.

Top module: `sfw_forward_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ld_sp_vld, rsp_st_vld and rsp_ld_vld are 0. The store cache is empty and the index allocator starts at 0.
- R2: A store-issue request writes st_wr_data into the value file at st_wr_idx only when st_wr_ivld is 1 and st_wr_filter (unsigned, 0 to 3) is 2 or 3. Otherwise the entry keeps its old contents.
- R3: A load-predict request with ld_pr_conf=1 gives ld_sp_vld=1 in the next cycle, with ld_sp_data equal to the entry at ld_pr_idx. A store write to the same entry in the same cycle is not seen by that read. Without ld_pr_conf, ld_sp_vld is 0 in the next cycle.
- R4: A store resolve with rs_st_ivld=0 returns rsp_st_ivld=1 and the filter unchanged. Its rsp_st_idx is the allocator value, which starts at 0 and grows by one, modulo the value-file depth, on each such allocation. The address is recorded with that index.
- R5: A store resolve with rs_st_ivld=1 keeps rs_idx. Its filter goes up by one, saturating at 3, if a load resolve hit that index since the index was last resolved by a store. Otherwise the filter goes down by one, saturating at 0. The address is recorded with rs_idx.
- R6: A load resolve whose address hits the store cache returns the index recorded for that exact address. The confidence bit is 1 unless the load mispredicted. On a miss, the confidence bit is 0 and rs_idx is returned unchanged.
- R7: rsp_ld_mispred is 1 exactly when rs_ld_spec=1 and rs_ld_spec_data differs from rs_ld_real_data. A mispredicted load always returns confidence 0.
- R8: Every resolve request gets exactly one response in the next cycle: on the store outputs when rs_is_load=0, and on the load outputs when it is 1. No response appears otherwise.
- R9: The store cache takes its set from the low address bits and has 4 ways. A new address that misses replaces the entry inserted earliest in its set, so a fifth distinct address in one set evicts the first. Re-recording an address already present updates its index in place and evicts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_wr_vld | input | 1 | Store-issue request |
| st_wr_filter | input | 2 | Store hint filter |
| st_wr_ivld | input | 1 | Store hint index-valid flag |
| st_wr_idx | input | IW | Store hint value-file index |
| st_wr_data | input | DW | Store data or source tag |
| ld_pr_vld | input | 1 | Load-predict request |
| ld_pr_conf | input | 1 | Load hint confidence bit |
| ld_pr_idx | input | IW | Load hint value-file index |
| ld_sp_vld | output | 1 | Speculative value valid |
| ld_sp_data | output | DW | Speculative value |
| rs_vld | input | 1 | Resolve request |
| rs_is_load | input | 1 | Resolve request is a load (1) or a store (0) |
| rs_addr | input | AW | Resolved memory address |
| rs_st_filter | input | 2 | Store hint filter being resolved |
| rs_st_ivld | input | 1 | Store hint index-valid flag being resolved |
| rs_idx | input | IW | Hint index of the resolving instruction |
| rs_ld_spec | input | 1 | Load used a speculative value |
| rs_ld_spec_data | input | DW | Value the load was given speculatively |
| rs_ld_real_data | input | DW | Real load data |
| rsp_st_vld | output | 1 | Updated store hint valid |
| rsp_st_filter | output | 2 | Updated store filter |
| rsp_st_ivld | output | 1 | Updated store index-valid flag |
| rsp_st_idx | output | IW | Updated store index |
| rsp_ld_vld | output | 1 | Updated load hint valid |
| rsp_ld_conf | output | 1 | Updated load confidence bit |
| rsp_ld_idx | output | IW | Updated load index |
| rsp_ld_mispred | output | 1 | Load misprediction flag |

## Verification
The bench drives a same-cycle write and read of one value-file entry. A design that forwards the write through would hand the load data it could not yet have. The bench walks the filter to both ends, with and without a consuming load. A filter that wraps instead of saturating would turn a quiet store into a forwarding one, or the reverse. It records a fifth address in one cache set and an existing address again. A design that evicts the wrong way, or duplicates a refreshed entry, would make later loads miss or return a stale index. A reference model checked every cycle also runs a mixed random stream, which catches an allocator that skips or repeats an index and a mispredict flag raised on loads that never speculated.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    typedef enum logic [1:0] {
        RS_IDLE      = 2'd0,
        RS_STORE_RSP = 2'd1,
        RS_LOAD_RSP  = 2'd2
    } rs_state_e;

    localparam logic [1:0] FILT_OPEN = 2'd2;
    localparam logic [1:0] FILT_MAX  = 2'd3;

    function automatic logic [1:0] filt_up(input logic [1:0] f);
        return (f == FILT_MAX) ? f : f + 2'd1;
    endfunction

    function automatic logic [1:0] filt_down(input logic [1:0] f);
        return (f == 2'd0) ? f : f - 2'd1;
    endfunction

    function automatic logic filt_allows(input logic [1:0] f);
        return f >= FILT_OPEN;
    endfunction

endpackage

// File: rtl/sfw_value_file.sv
module sfw_value_file #(
    parameter int IW = 10,
    parameter int DW = 32,
    localparam int DEPTH = 1 << IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_vld,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];

    // write port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // registered read: a same-edge write is not visible
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem_q[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld <= 1'b0;
        end else begin
            rd_vld <= rd_en;
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_vld); // R3
    AST_NO_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_vld); // R3
    AST_DATA_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> $stable(rd_data)); // R3

endmodule

// File: rtl/sfw_store_cache.sv
module sfw_store_cache #(
    parameter int AW      = 32,
    parameter int IW      = 10,
    parameter int ENTRIES = 1024,
    parameter int WAYS    = 4,
    localparam int SETS   = ENTRIES / WAYS,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int TAG_W  = AW - SET_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [IW-1:0] lk_idx,
    input  logic          ins_en,
    input  logic [IW-1:0] ins_idx
);

    logic [SET_W-1:0] set_sel;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] hit_way;

    logic             valid_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [IW-1:0]    idx_q   [SETS][WAYS];
    logic [WAY_W-1:0] rr_q    [SETS];

    assign set_sel = lk_addr[SET_W-1:0];
    assign lk_tag  = lk_addr[AW-1:SET_W];

    // per-way tag compare
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = valid_q[set_sel][w] && (tag_q[set_sel][w] == lk_tag);
    end

    assign lk_hit = |hit_vec;

    always_comb begin
        lk_idx  = '0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                lk_idx  = lk_idx | idx_q[set_sel][w];
                hit_way = WAY_W'(w);
            end
        end
    end

    // valid bits and replacement pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                end
            end
        end else if (ins_en && !lk_hit) begin
            valid_q[set_sel][rr_q[set_sel]] <= 1'b1;
            rr_q[set_sel]                   <= rr_q[set_sel] + WAY_W'(1);
        end
    end

    // tag and index storage
    always_ff @(posedge clk) begin
        if (ins_en) begin
            if (lk_hit) begin
                idx_q[set_sel][hit_way] <= ins_idx;
            end else begin
                tag_q[set_sel][rr_q[set_sel]] <= lk_tag;
                idx_q[set_sel][rr_q[set_sel]] <= ins_idx;
            end
        end
    end

    AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec)); // R9

endmodule

// File: rtl/sfw_hint_update.sv
module sfw_hint_update
    import sfw_pkg::*;
#(
    parameter int IW = 10,
    parameter int DW = 32,
    localparam int DEPTH = 1 << IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rs_vld,
    input  logic          rs_is_load,
    input  logic [1:0]    rs_st_filter,
    input  logic          rs_st_ivld,
    input  logic [IW-1:0] rs_idx,
    input  logic          rs_ld_spec,
    input  logic [DW-1:0] rs_ld_spec_data,
    input  logic [DW-1:0] rs_ld_real_data,
    input  logic          sc_hit,
    input  logic [IW-1:0] sc_idx,
    output logic          sc_ins_en,
    output logic [IW-1:0] sc_ins_idx,
    output logic          rsp_st_vld,
    output logic [1:0]    rsp_st_filter,
    output logic          rsp_st_ivld,
    output logic [IW-1:0] rsp_st_idx,
    output logic          rsp_ld_vld,
    output logic          rsp_ld_conf,
    output logic [IW-1:0] rsp_ld_idx,
    output logic          rsp_ld_mispred
);

    rs_state_e state_q, state_d;

    logic [DEPTH-1:0] consumed_q;
    logic [IW-1:0]    alloc_q;

    logic          st_fresh;
    logic [IW-1:0] st_idx_n;
    logic [1:0]    st_filt_n;
    logic          ld_mis_n;
    logic          ld_conf_n;
    logic [IW-1:0] ld_idx_n;

    logic [1:0]    st_filt_q;
    logic          st_ivld_q;
    logic [IW-1:0] st_idx_q;
    logic          ld_conf_q;
    logic [IW-1:0] ld_idx_q;
    logic          ld_mis_q;

    // per-request hint computation
    always_comb begin
        st_fresh  = !rs_st_ivld;
        st_idx_n  = st_fresh ? alloc_q : rs_idx;
        if (st_fresh) begin
            st_filt_n = rs_st_filter;
        end else if (consumed_q[rs_idx]) begin
            st_filt_n = filt_up(rs_st_filter);
        end else begin
            st_filt_n = filt_down(rs_st_filter);
        end
        ld_mis_n  = rs_ld_spec && (rs_ld_spec_data != rs_ld_real_data);
        ld_conf_n = sc_hit && !ld_mis_n;
        ld_idx_n  = sc_hit ? sc_idx : rs_idx;
    end

    assign sc_ins_en  = rs_vld && !rs_is_load;
    assign sc_ins_idx = st_idx_n;

    // next-state logic
    always_comb begin
        state_d = RS_IDLE;
        unique case (state_q)
            RS_IDLE, RS_STORE_RSP, RS_LOAD_RSP: begin
                if (rs_vld) begin
                    state_d = rs_is_load ? RS_LOAD_RSP : RS_STORE_RSP;
                end else begin
                    state_d = RS_IDLE;
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // response payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_filt_q <= '0;
            st_ivld_q <= 1'b0;
            st_idx_q  <= '0;
            ld_conf_q <= 1'b0;
            ld_idx_q  <= '0;
            ld_mis_q  <= 1'b0;
        end else if (rs_vld) begin
            if (rs_is_load) begin
                ld_conf_q <= ld_conf_n;
                ld_idx_q  <= ld_idx_n;
                ld_mis_q  <= ld_mis_n;
            end else begin
                st_filt_q <= st_filt_n;
                st_ivld_q <= 1'b1;
                st_idx_q  <= st_idx_n;
            end
        end
    end

    // allocator and consumption tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            consumed_q <= '0;
            alloc_q    <= '0;
        end else if (rs_vld) begin
            if (!rs_is_load) begin
                consumed_q[st_idx_n] <= 1'b0;
                if (st_fresh) begin
                    alloc_q <= alloc_q + IW'(1);
                end
            end else if (sc_hit) begin
                consumed_q[sc_idx] <= 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        rsp_st_vld     = 1'b0;
        rsp_ld_vld     = 1'b0;
        unique case (state_q)
            RS_IDLE:      ;
            RS_STORE_RSP: rsp_st_vld = 1'b1;
            RS_LOAD_RSP:  rsp_ld_vld = 1'b1;
            default:      ;
        endcase
        rsp_st_filter  = st_filt_q;
        rsp_st_ivld    = st_ivld_q;
        rsp_st_idx     = st_idx_q;
        rsp_ld_conf    = ld_conf_q;
        rsp_ld_idx     = ld_idx_q;
        rsp_ld_mispred = ld_mis_q;
    end

    AST_RSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rsp_st_vld, rsp_ld_vld})); // R8
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) rs_vld |=> (rsp_st_vld || rsp_ld_vld)); // R8
    AST_STORE_IDX_VALID: assert property (@(posedge clk) disable iff (!rst_n) rsp_st_vld |-> rsp_st_ivld); // R4
    AST_FRESH_KEEPS_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_st_vld && !$past(rs_st_ivld)) |-> (rsp_st_filter == $past(rs_st_filter))); // R4
    AST_FILTER_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_st_vld && $past(rs_st_ivld)) |->
        ((rsp_st_filter != $past(rs_st_filter)) || (rsp_st_filter == 2'd0) || (rsp_st_filter == 2'd3))); // R5
    AST_MISPRED_NO_CONF: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ld_vld && rsp_ld_mispred) |-> !rsp_ld_conf); // R7

endmodule

// File: rtl/sfw_forward_unit.sv
module sfw_forward_unit
    import sfw_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int VF_ENTRIES = 1024,
    parameter int SC_ENTRIES = 1024,
    parameter int SC_WAYS    = 4,
    localparam int IW        = $clog2(VF_ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_wr_vld,
    input  logic [1:0]    st_wr_filter,
    input  logic          st_wr_ivld,
    input  logic [IW-1:0] st_wr_idx,
    input  logic [DW-1:0] st_wr_data,
    input  logic          ld_pr_vld,
    input  logic          ld_pr_conf,
    input  logic [IW-1:0] ld_pr_idx,
    output logic          ld_sp_vld,
    output logic [DW-1:0] ld_sp_data,
    input  logic          rs_vld,
    input  logic          rs_is_load,
    input  logic [AW-1:0] rs_addr,
    input  logic [1:0]    rs_st_filter,
    input  logic          rs_st_ivld,
    input  logic [IW-1:0] rs_idx,
    input  logic          rs_ld_spec,
    input  logic [DW-1:0] rs_ld_spec_data,
    input  logic [DW-1:0] rs_ld_real_data,
    output logic          rsp_st_vld,
    output logic [1:0]    rsp_st_filter,
    output logic          rsp_st_ivld,
    output logic [IW-1:0] rsp_st_idx,
    output logic          rsp_ld_vld,
    output logic          rsp_ld_conf,
    output logic [IW-1:0] rsp_ld_idx,
    output logic          rsp_ld_mispred
);

    logic          vf_wr_en;
    logic          vf_rd_en;
    logic          sc_hit;
    logic [IW-1:0] sc_idx;
    logic          sc_ins_en;
    logic [IW-1:0] sc_ins_idx;

    assign vf_wr_en = st_wr_vld && st_wr_ivld && filt_allows(st_wr_filter);
    assign vf_rd_en = ld_pr_vld && ld_pr_conf;

    sfw_value_file #(.IW(IW), .DW(DW)) u_vf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (vf_wr_en),
        .wr_idx  (st_wr_idx),
        .wr_data (st_wr_data),
        .rd_en   (vf_rd_en),
        .rd_idx  (ld_pr_idx),
        .rd_vld  (ld_sp_vld),
        .rd_data (ld_sp_data)
    );

    sfw_store_cache #(.AW(AW), .IW(IW), .ENTRIES(SC_ENTRIES), .WAYS(SC_WAYS)) u_sc (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_addr (rs_addr),
        .lk_hit  (sc_hit),
        .lk_idx  (sc_idx),
        .ins_en  (sc_ins_en),
        .ins_idx (sc_ins_idx)
    );

    sfw_hint_update #(.IW(IW), .DW(DW)) u_hint (
        .clk             (clk),
        .rst_n           (rst_n),
        .rs_vld          (rs_vld),
        .rs_is_load      (rs_is_load),
        .rs_st_filter    (rs_st_filter),
        .rs_st_ivld      (rs_st_ivld),
        .rs_idx          (rs_idx),
        .rs_ld_spec      (rs_ld_spec),
        .rs_ld_spec_data (rs_ld_spec_data),
        .rs_ld_real_data (rs_ld_real_data),
        .sc_hit          (sc_hit),
        .sc_idx          (sc_idx),
        .sc_ins_en       (sc_ins_en),
        .sc_ins_idx      (sc_ins_idx),
        .rsp_st_vld      (rsp_st_vld),
        .rsp_st_filter   (rsp_st_filter),
        .rsp_st_ivld     (rsp_st_ivld),
        .rsp_st_idx      (rsp_st_idx),
        .rsp_ld_vld      (rsp_ld_vld),
        .rsp_ld_conf     (rsp_ld_conf),
        .rsp_ld_idx      (rsp_ld_idx),
        .rsp_ld_mispred  (rsp_ld_mispred)
    );

    AST_NO_SPEC_AFTER_RESET: assert property (@(posedge clk) !rst_n |=> (!ld_sp_vld && !rsp_st_vld && !rsp_ld_vld)); // R1

endmodule

// File: tb/tb_sfw_forward_unit.sv
`timescale 1ns/1ps
module tb_sfw_forward_unit;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int IW = 10;
    localparam int DEPTH = 1024;
    localparam int SETS = 256;
    localparam int WAYS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_wr_vld = 0, st_wr_ivld = 0;
    logic [1:0]    st_wr_filter = 0;
    logic [IW-1:0] st_wr_idx = 0;
    logic [DW-1:0] st_wr_data = 0;
    logic          ld_pr_vld = 0, ld_pr_conf = 0;
    logic [IW-1:0] ld_pr_idx = 0;
    logic          ld_sp_vld;
    logic [DW-1:0] ld_sp_data;
    logic          rs_vld = 0, rs_is_load = 0, rs_st_ivld = 0, rs_ld_spec = 0;
    logic [AW-1:0] rs_addr = 0;
    logic [1:0]    rs_st_filter = 0;
    logic [IW-1:0] rs_idx = 0;
    logic [DW-1:0] rs_ld_spec_data = 0, rs_ld_real_data = 0;
    logic          rsp_st_vld, rsp_st_ivld, rsp_ld_vld, rsp_ld_conf, rsp_ld_mispred;
    logic [1:0]    rsp_st_filter;
    logic [IW-1:0] rsp_st_idx, rsp_ld_idx;

    sfw_forward_unit dut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit checking = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct { logic [AW-1:0] a; int idx; } ent_t;
    ent_t          sc_q [SETS][$];
    logic [DW-1:0] m_vf [DEPTH];
    bit            m_wr [DEPTH];
    bit            m_cons [DEPTH];
    int            m_alloc;

    bit            e_sp_vld, e_sp_known;
    logic [DW-1:0] e_sp_data;
    bit            e_st_vld, e_ld_vld, e_ld_conf, e_ld_mis;
    int            e_st_filt, e_st_idx, e_ld_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (sc_q[s]) sc_q[s].delete();
            foreach (m_wr[i]) begin m_wr[i] = 0; m_cons[i] = 0; end
            m_alloc = 0;
            e_sp_vld = 0; e_st_vld = 0; e_ld_vld = 0;
        end else begin
            e_sp_vld = ld_pr_vld && ld_pr_conf;
            if (e_sp_vld) begin
                e_sp_known = m_wr[ld_pr_idx];
                e_sp_data  = m_vf[ld_pr_idx];
            end
            if (st_wr_vld && st_wr_ivld && st_wr_filter >= 2) begin
                m_vf[st_wr_idx] = st_wr_data;
                m_wr[st_wr_idx] = 1;
            end
            e_st_vld = 0; e_ld_vld = 0;
            if (rs_vld) begin
                int s, found;
                s = int'(rs_addr[7:0]);
                found = -1;
                foreach (sc_q[s][k]) if (sc_q[s][k].a == rs_addr) found = k;
                if (!rs_is_load) begin
                    int f;
                    f = rs_st_filter;
                    if (!rs_st_ivld) begin
                        e_st_idx = m_alloc;
                        m_alloc = (m_alloc + 1) % DEPTH;
                    end else begin
                        e_st_idx = rs_idx;
                        if (m_cons[rs_idx]) f = (f == 3) ? 3 : f + 1;
                        else f = (f == 0) ? 0 : f - 1;
                    end
                    e_st_filt = f;
                    m_cons[e_st_idx] = 0;
                    if (found >= 0) sc_q[s][found].idx = e_st_idx;
                    else begin
                        ent_t n;
                        if (sc_q[s].size() == WAYS) void'(sc_q[s].pop_front());
                        n.a = rs_addr; n.idx = e_st_idx;
                        sc_q[s].push_back(n);
                    end
                    e_st_vld = 1;
                end else begin
                    e_ld_mis = rs_ld_spec && (rs_ld_spec_data != rs_ld_real_data);
                    if (found >= 0) begin
                        e_ld_idx = sc_q[s][found].idx;
                        m_cons[e_ld_idx] = 1;
                        e_ld_conf = !e_ld_mis;
                    end else begin
                        e_ld_idx = rs_idx;
                        e_ld_conf = 0;
                    end
                    e_ld_vld = 1;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (checking) begin
            chk("R3 ld_sp_vld", 64'(ld_sp_vld), 64'(e_sp_vld));
            if (e_sp_vld && e_sp_known) chk("R2 R3 ld_sp_data", 64'(ld_sp_data), 64'(e_sp_data));
            chk("R8 rsp_st_vld", 64'(rsp_st_vld), 64'(e_st_vld));
            chk("R8 rsp_ld_vld", 64'(rsp_ld_vld), 64'(e_ld_vld));
            if (e_st_vld) begin
                chk("R4 rsp_st_ivld", 64'(rsp_st_ivld), 64'd1);
                chk("R4 R5 rsp_st_idx", 64'(rsp_st_idx), 64'(e_st_idx));
                chk("R5 rsp_st_filter", 64'(rsp_st_filter), 64'(e_st_filt));
            end
            if (e_ld_vld) begin
                chk("R6 R9 rsp_ld_idx", 64'(rsp_ld_idx), 64'(e_ld_idx));
                chk("R6 rsp_ld_conf", 64'(rsp_ld_conf), 64'(e_ld_conf));
                chk("R7 rsp_ld_mispred", 64'(rsp_ld_mispred), 64'(e_ld_mis));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
        st_wr_vld = 0; ld_pr_vld = 0; rs_vld = 0;
    endtask

    task automatic swr(input logic [1:0] f, input logic iv, input int idx, input logic [DW-1:0] d);
        st_wr_vld = 1; st_wr_filter = f; st_wr_ivld = iv; st_wr_idx = IW'(idx); st_wr_data = d;
    endtask

    task automatic lpr(input logic c, input int idx);
        ld_pr_vld = 1; ld_pr_conf = c; ld_pr_idx = IW'(idx);
    endtask

    task automatic sres(input logic [AW-1:0] a, input logic [1:0] f, input logic iv, input int idx);
        rs_vld = 1; rs_is_load = 0; rs_addr = a; rs_st_filter = f; rs_st_ivld = iv; rs_idx = IW'(idx);
    endtask

    task automatic lres(input logic [AW-1:0] a, input int idx, input logic sp,
                        input logic [DW-1:0] sd, input logic [DW-1:0] rd);
        rs_vld = 1; rs_is_load = 1; rs_addr = a; rs_idx = IW'(idx);
        rs_ld_spec = sp; rs_ld_spec_data = sd; rs_ld_real_data = rd;
    endtask

    function automatic logic [AW-1:0] mk(input int tag, input int set);
        return AW'((tag << 8) | set);
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        chk("R1 ld_sp_vld reset", 64'(ld_sp_vld), 64'd0);
        chk("R1 rsp_st_vld reset", 64'(rsp_st_vld), 64'd0);
        chk("R1 rsp_ld_vld reset", 64'(rsp_ld_vld), 64'd0);
        rst_n = 1;
        checking = 1;
        tick();

        // R1/R4: fresh stores take indices 0,1,2; load to unseen address misses
        lres(mk(9, 3), 7, 0, 0, 0); tick();
        sres(mk(1, 0), 2'd3, 0, 0); tick();
        sres(mk(2, 0), 2'd1, 0, 0); tick();
        sres(mk(3, 5), 2'd2, 0, 0); tick();

        // R2: gated writes
        swr(2'd3, 1, 1, 32'hC0C0); tick();
        swr(2'd2, 1, 0, 32'hAAAA); tick();
        swr(2'd1, 1, 1, 32'hBBBB); tick();  // filter closed
        swr(2'd3, 0, 1, 32'hDDDD); tick();  // index not valid
        // R3: confident and unconfident predicts
        lpr(1, 1); tick();
        lpr(0, 0); tick();
        lpr(1, 0); tick();
        // R3: same-cycle write and read of one entry returns old data
        swr(2'd3, 1, 0, 32'h1234); lpr(1, 0); tick();
        lpr(1, 0); tick();

        // R6/R7: load resolves
        lres(mk(1, 0), 5, 1, 32'h1234, 32'h1234); tick();   // correct
        lres(mk(2, 0), 5, 1, 32'h1, 32'h2); tick();         // mispredict
        lres(mk(7, 0), 6, 1, 32'h3, 32'h4); tick();         // miss + mispredict
        lres(mk(3, 5), 6, 0, 32'h3, 32'h4); tick();         // hit, no spec

        // R5: filter training
        sres(mk(1, 0), 2'd1, 1, 0); tick();   // consumed -> 2
        sres(mk(1, 0), 2'd2, 1, 0); tick();   // not consumed -> 1
        sres(mk(1, 0), 2'd0, 1, 0); tick();   // saturate at 0
        lres(mk(1, 0), 0, 0, 0, 0); tick();
        sres(mk(1, 0), 2'd3, 1, 0); tick();   // saturate at 3

        // R9: five addresses in set 9, first evicted; refresh does not evict
        for (int t = 1; t <= 4; t++) begin sres(mk(t, 9), 2'd2, 0, 0); tick(); end
        sres(mk(2, 9), 2'd2, 1, 100); tick();  // refresh in place
        lres(mk(1, 9), 0, 0, 0, 0); tick();    // still present
        sres(mk(5, 9), 2'd2, 0, 0); tick();    // evicts tag 1
        lres(mk(1, 9), 11, 0, 0, 0); tick();   // miss
        lres(mk(2, 9), 0, 0, 0, 0); tick();    // hit idx 100
        lres(mk(5, 9), 0, 0, 0, 0); tick();

        // R8 and mixed stream
        for (int c = 0; c < 400; c++) begin
            int k;
            if ($urandom_range(0, 1) == 1)
                swr(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom);
            if ($urandom_range(0, 1) == 1)
                lpr(1'($urandom_range(0, 1)), $urandom_range(0, 7));
            k = $urandom_range(0, 11);
            case ($urandom_range(0, 2))
                0: sres(mk(k / 2, k % 2), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom_range(0, 7));
                1: lres(mk(k / 2, k % 2), $urandom_range(0, 7), 1'($urandom_range(0, 1)),
                        DW'($urandom_range(0, 1)), DW'($urandom_range(0, 1)));
                default: ;
            endcase
            tick();
        end
        tick();
        tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule